// File: doc/BRIEF.md
# Single-Cycle 32-bit MIPS Subset Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. Each cycle it fetches a word from an external instruction ROM at the current program counter. It decodes that word and reads two source registers from its own 32-entry register file. The core then computes a result in an ALU and shifter, which may go to an external data RAM, and writes the result back. At the same clock edge it moves to the next program counter. Branches and jumps take effect at once: there is no delay slot.

The core is placed between a combinational-read instruction ROM and a data RAM with one access per cycle. The RAM stores on a rising edge and reads combinationally. The program counter starts at byte address 0, and programs usually place their data at byte address 0x00002000. A set of debug outputs shows five architectural registers, the fetch address and the current instruction word, so a bench or a monitor can follow execution. A program that runs past its last instruction reads all-zero words and idles harmlessly.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the program counter returns to 0 and all 32 registers are cleared. After reset, `imem_addr`, `dbg_pc` and all five debug registers read 0.
- R2: R-type words (opcode 0x00, fields rs[25:21], rt[20:16], rd[15:11], funct[5:0]) with funct add 0x20, addu 0x21, and 0x24, or 0x25, slt 0x2A and sltu 0x2B write rs op rt into rd. add and addu both give the wrapped 32-bit sum and never trap. slt compares as signed and sltu as unsigned, and each writes 1 or 0.
- R3: I-type words (rs[25:21], rt[20:16], imm[15:0]) write rs op ext(imm) into rt. This applies to addi 0x08 and addiu 0x09 (wrapped sum), slti 0x0A (signed compare) and sltiu 0x0B (the sign-extended immediate compared as unsigned), all with a sign-extended immediate. andi 0x0C and ori 0x0D use a zero-extended immediate.
- R4: Shifts (opcode 0x00, funct sll 0x00, srl 0x02, sra 0x03) write rt shifted by shamt[10:6] into rd. srl fills with zeros and sra copies the sign bit.
- R5: lui (opcode 0x0F) writes imm[15:0] into the upper half of rt and zeros into the lower half.
- R6: A write that targets register 0 is discarded, and register 0 always reads as 0.
- R7: sw (opcode 0x2B) drives `dmem_addr` = rs + sign-extended imm, `dmem_wdata` = rt and `dmem_we` = 1. lw (opcode 0x23) loads `dmem_rdata` from that same address into rt. For every other opcode, `dmem_we` is 0.
- R8: beq (opcode 0x04) branches when rs equals rt, and bne (opcode 0x05) branches when they differ. A taken branch goes to PC+4 + (sign-extended imm << 2). An untaken branch goes to PC+4.
- R9: j (opcode 0x02) and jal (opcode 0x03) go to {PC+4[31:28], index[25:0], 2'b00}. jal also writes PC+4 into register 31.
- R10: jr (opcode 0x00, funct 0x08) loads the program counter with rs.
- R11: Every other instruction, including the all-zero word, advances the program counter by 4. The all-zero word leaves all registers unchanged.
- R12: `dbg_s0`, `dbg_s1`, `dbg_s2`, `dbg_ra` and `dbg_sp` show registers 16, 17, 18, 31 and 29. `dbg_pc` shows the fetch address, and `dbg_instr` shows the instruction word being executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction fetch |
| imem_word | input | 32 | Instruction word returned by the ROM |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken on the next rising edge |
| dmem_rdata | input | 32 | Load data, combinational from the RAM |
| dbg_s0 | output | 32 | Register 16 |
| dbg_s1 | output | 32 | Register 17 |
| dbg_s2 | output | 32 | Register 18 |
| dbg_ra | output | 32 | Register 31 |
| dbg_sp | output | 32 | Register 29 |
| dbg_pc | output | 32 | Current program counter |
| dbg_instr | output | 32 | Instruction currently executing |

## Verification
The assertions check the control-flow rules on every cycle:
- the fetch address returns to 0 after reset;
- the fetch address advances by exactly 4 for every non-control-flow word;
- direct jumps land on the concatenated target;
- jal links PC+4;
- the store strobe is raised for store opcodes only;
- an all-zero word changes no visible register.

The bench's scenarios cover the data results. It sweeps every supported ALU, immediate and shift operation over operand pairs that include the sign and carry boundaries. It also runs loads and stores with positive and negative offsets, and discarded writes to register 0. Further scenarios cover a backward loop with taken and untaken branches and a jal/jr call-return sequence. Only these scenarios can show those results.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN     = 32;
    localparam int REG_AW   = 5;
    localparam int LINK_REG = 31;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_ADDIU = 6'h09;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_SLTIU = 6'h0B;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_AND, ALU_OR, ALU_SLT, ALU_SLTU,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] { DST_RT, DST_RD, DST_LINK } dst_e;
    typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_e;
    typedef enum logic [1:0] { NPC_SEQ, NPC_BRANCH, NPC_JUMP, NPC_REG } npc_e;

    typedef struct packed {
        logic    reg_we;
        dst_e    dst;
        wb_e     wb;
        logic    use_imm;
        logic    zero_ext;
        alu_op_e alu;
        logic    mem_we;
        npc_e    npc;
        logic    br_ne;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]        op;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    function automatic logic [XLEN-1:0] ext_imm(input logic [15:0] imm, input logic zero);
        return zero ? {16'h0000, imm} : {{(XLEN-16){imm[15]}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] branch_tgt(input logic [XLEN-1:0] pc4,
                                                   input logic [15:0] imm);
        return pc4 + {{(XLEN-18){imm[15]}}, imm, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] jump_tgt(input logic [XLEN-1:0] pc4,
                                                 input logic [25:0] idx);
        return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/sc_core_decode.sv
module sc_core_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.dst      = DST_RT;
        ctrl.wb       = WB_ALU;
        ctrl.alu      = ALU_ADD;
        ctrl.npc      = NPC_SEQ;
        case (op)
            OP_RTYPE: begin
                ctrl.dst    = DST_RD;
                ctrl.reg_we = 1'b1;
                case (funct)
                    FN_SLL:  ctrl.alu = ALU_SLL;
                    FN_SRL:  ctrl.alu = ALU_SRL;
                    FN_SRA:  ctrl.alu = ALU_SRA;
                    FN_ADD, FN_ADDU: ctrl.alu = ALU_ADD;
                    FN_AND:  ctrl.alu = ALU_AND;
                    FN_OR:   ctrl.alu = ALU_OR;
                    FN_SLT:  ctrl.alu = ALU_SLT;
                    FN_SLTU: ctrl.alu = ALU_SLTU;
                    FN_JR: begin
                        ctrl.reg_we = 1'b0;
                        ctrl.npc    = NPC_REG;
                    end
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OP_J:   ctrl.npc = NPC_JUMP;
            OP_JAL: begin
                ctrl.npc    = NPC_JUMP;
                ctrl.reg_we = 1'b1;
                ctrl.dst    = DST_LINK;
                ctrl.wb     = WB_LINK;
            end
            OP_BEQ: ctrl.npc = NPC_BRANCH;
            OP_BNE: begin
                ctrl.npc   = NPC_BRANCH;
                ctrl.br_ne = 1'b1;
            end
            OP_ADDI, OP_ADDIU: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_ADD;
            end
            OP_SLTI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_SLT;
            end
            OP_SLTIU: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_SLTU;
            end
            OP_ANDI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.zero_ext = 1'b1;
                ctrl.alu = ALU_AND;
            end
            OP_ORI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.zero_ext = 1'b1;
                ctrl.alu = ALU_OR;
            end
            OP_LUI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_LUI;
            end
            OP_LW: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.wb = WB_MEM;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1; ctrl.mem_we = 1'b1;
            end
            default: ctrl.reg_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [4:0]   shamt,
    output logic [W-1:0] y
);
    localparam int HALF = W / 2;

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            ALU_SLL:  y = b << shamt;
            ALU_SRL:  y = b >> shamt;
            ALU_SRA:  y = $unsigned($signed(b) >>> shamt);
            ALU_LUI:  y = {b[HALF-1:0], {HALF{1'b0}}};
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    parameter int NTAP  = 5,
    parameter logic [NTAP*8-1:0] TAP_IDX = {8'd29, 8'd31, 8'd18, 8'd17, 8'd16}
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREGS)-1:0] ra_a,
    input  logic [$clog2(NREGS)-1:0] ra_b,
    output logic [W-1:0]             rd_a,
    output logic [W-1:0]             rd_b,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [W-1:0]             wd,
    output logic [NTAP-1:0][W-1:0]   taps
);
    localparam int AW = $clog2(NREGS);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign taps[t] = regs[TAP_IDX[t*8 +: AW]];
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_word,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    output logic [31:0] dbg_s0,
    output logic [31:0] dbg_s1,
    output logic [31:0] dbg_s2,
    output logic [31:0] dbg_ra,
    output logic [31:0] dbg_sp,
    output logic [31:0] dbg_pc,
    output logic [31:0] dbg_instr
);
    localparam int NTAP = 5;

    logic [XLEN-1:0] pc_q, pc4, pc_next;
    instr_t          ins;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, wb_val;
    logic [REG_AW-1:0] wa;
    logic            taken;
    logic [NTAP-1:0][XLEN-1:0] taps;

    assign ins = instr_t'(imem_word);
    assign pc4 = pc_q + 32'd4;

    sc_core_decode u_dec (
        .op    (ins.op),
        .funct (ins.funct),
        .ctrl  (ctrl)
    );

    sc_core_regfile #(
        .W     (XLEN),
        .NREGS (32),
        .NTAP  (NTAP)
    ) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (ins.rs),
        .ra_b (ins.rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (ctrl.reg_we),
        .wa   (wa),
        .wd   (wb_val),
        .taps (taps)
    );

    assign imm_x = ext_imm(imem_word[15:0], ctrl.zero_ext);
    assign alu_b = ctrl.use_imm ? imm_x : rt_val;

    sc_core_alu #(.W(XLEN)) u_alu (
        .op    (ctrl.alu),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (ins.shamt),
        .y     (alu_y)
    );

    always_comb begin
        case (ctrl.dst)
            DST_RD:   wa = ins.rd;
            DST_LINK: wa = REG_AW'(LINK_REG);
            default:  wa = ins.rt;
        endcase
        case (ctrl.wb)
            WB_MEM:  wb_val = dmem_rdata;
            WB_LINK: wb_val = pc4;
            default: wb_val = alu_y;
        endcase
    end

    assign taken = ctrl.br_ne ? (rs_val != rt_val) : (rs_val == rt_val);

    always_comb begin
        case (ctrl.npc)
            NPC_BRANCH: pc_next = taken ? branch_tgt(pc4, imem_word[15:0]) : pc4;
            NPC_JUMP:   pc_next = jump_tgt(pc4, imem_word[25:0]);
            NPC_REG:    pc_next = rs_val;
            default:    pc_next = pc4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_next;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

    assign dbg_s0    = taps[0];
    assign dbg_s1    = taps[1];
    assign dbg_s2    = taps[2];
    assign dbg_ra    = taps[3];
    assign dbg_sp    = taps[4];
    assign dbg_pc    = pc_q;
    assign dbg_instr = imem_word;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_word,
    input logic        dmem_we,
    input logic [31:0] dbg_s0,
    input logic [31:0] dbg_s1,
    input logic [31:0] dbg_s2,
    input logic [31:0] dbg_ra,
    input logic [31:0] dbg_sp
);
    logic [5:0] op_w;
    logic       is_flow;
    assign op_w    = imem_word[31:26];
    assign is_flow = (op_w == 6'h02) || (op_w == 6'h03) || (op_w == 6'h04) ||
                     (op_w == 6'h05) || ((op_w == 6'h00) && (imem_word[5:0] == 6'h08));

    // R1
    reset_pc_chk: assert property (@(posedge clk) $past(rst) |-> (imem_addr == 32'h0));

    // R11
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        !is_flow |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R11
    nop_word_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_word == 32'h0) |=> $stable({dbg_s0, dbg_s1, dbg_s2, dbg_ra, dbg_sp}));

    // R7
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we == (op_w == 6'h2B));

    // R9
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_w == 6'h02) || (op_w == 6'h03)) |=>
        (imem_addr == {$past(imem_addr[31:28] + ((imem_addr[27:2] == 26'h3FFFFFF) ? 4'd1 : 4'd0)),
                       $past(imem_word[25:0]), 2'b00}));

    // R9
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        (op_w == 6'h03) |=> (dbg_ra == $past(imem_addr) + 32'd4));
endmodule

bind sc_core sc_core_chk u_chk (.*);

// File: tb/sc_core_test.sv
module sc_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_word, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] dbg_s0, dbg_s1, dbg_s2, dbg_ra, dbg_sp, dbg_pc, dbg_instr;

    logic [31:0] rom [64];
    logic [31:0] ram [64];
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    assign imem_word  = rom[imem_addr[7:2]];
    assign dmem_rdata = ram[dmem_addr[7:2]];
    always_ff @(posedge clk) if (dmem_we) ram[dmem_addr[7:2]] <= dmem_wdata;

    sc_core uut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_word(imem_word),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .dbg_s0(dbg_s0), .dbg_s1(dbg_s1), .dbg_s2(dbg_s2),
        .dbg_ra(dbg_ra), .dbg_sp(dbg_sp), .dbg_pc(dbg_pc), .dbg_instr(dbg_instr)
    );

    function automatic logic [31:0] rt_w(input logic [5:0] fn, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [4:0] rd,
                                         input logic [4:0] sh);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction
    function automatic logic [31:0] it_w(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 64; i++) rom[i] = 32'h0;
    endtask

    task automatic restart();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic [31:0] vals [6];
    logic [31:0] expv [20];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_8765;
        for (int i = 0; i < 64; i++) ram[i] = 32'h0;

        // reset state
        clear_rom();
        rom[0] = it_w(6'h09, 0, 16, 16'h0011);
        restart();
        chk("R1 pc after reset", dbg_pc, 32'h0);
        chk("R1 fetch addr after reset", imem_addr, 32'h0);
        chk("R1 debug regs after reset", dbg_s0 | dbg_s1 | dbg_s2 | dbg_ra | dbg_sp, 32'h0);
        chk("R12 instr shown", dbg_instr, rom[0]);

        // operand sweep over ALU, immediate and shift forms
        for (int ia = 0; ia < 6; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
                logic [31:0] a, b, se, ze;
                logic [15:0] im;
                logic [4:0]  sh;
                a = vals[ia]; b = vals[ib]; im = b[15:0]; sh = a[4:0];
                se = {{16{im[15]}}, im}; ze = {16'h0, im};
                clear_rom();
                rom[0]  = it_w(6'h0F, 0, 16, a[31:16]);
                rom[1]  = it_w(6'h0D, 16, 16, a[15:0]);
                rom[2]  = it_w(6'h0F, 0, 17, b[31:16]);
                rom[3]  = it_w(6'h0D, 17, 17, b[15:0]);
                rom[4]  = rt_w(6'h20, 16, 17, 18, 0);  expv[4]  = a + b;
                rom[5]  = rt_w(6'h21, 16, 17, 18, 0);  expv[5]  = a + b;
                rom[6]  = rt_w(6'h24, 16, 17, 18, 0);  expv[6]  = a & b;
                rom[7]  = rt_w(6'h25, 16, 17, 18, 0);  expv[7]  = a | b;
                rom[8]  = rt_w(6'h2A, 16, 17, 18, 0);  expv[8]  = ($signed(a) < $signed(b)) ? 1 : 0;
                rom[9]  = rt_w(6'h2B, 16, 17, 18, 0);  expv[9]  = (a < b) ? 1 : 0;
                rom[10] = it_w(6'h08, 16, 18, im);     expv[10] = a + se;
                rom[11] = it_w(6'h09, 16, 18, im);     expv[11] = a + se;
                rom[12] = it_w(6'h0A, 16, 18, im);     expv[12] = ($signed(a) < $signed(se)) ? 1 : 0;
                rom[13] = it_w(6'h0B, 16, 18, im);     expv[13] = (a < se) ? 1 : 0;
                rom[14] = it_w(6'h0C, 16, 18, im);     expv[14] = a & ze;
                rom[15] = it_w(6'h0D, 16, 18, im);     expv[15] = a | ze;
                rom[16] = rt_w(6'h00, 0, 17, 18, sh);  expv[16] = b << sh;
                rom[17] = rt_w(6'h02, 0, 17, 18, sh);  expv[17] = b >> sh;
                rom[18] = rt_w(6'h03, 0, 17, 18, sh);  expv[18] = $unsigned($signed(b) >>> sh);
                rom[19] = it_w(6'h0F, 0, 18, im);      expv[19] = {im, 16'h0};
                restart();
                step(4);
                chk("R5 operand a via lui/ori", dbg_s0, a);
                chk("R5 operand b via lui/ori", dbg_s1, b);
                for (int k = 4; k < 20; k++) begin
                    step(1);
                    if (k < 10)       chk($sformatf("R2 rtype slot %0d a=%h b=%h", k, a, b), dbg_s2, expv[k]);
                    else if (k < 16)  chk($sformatf("R3 itype slot %0d a=%h b=%h", k, a, b), dbg_s2, expv[k]);
                    else if (k < 19)  chk($sformatf("R4 shift slot %0d sh=%0d b=%h", k, sh, b), dbg_s2, expv[k]);
                    else              chk($sformatf("R5 lui imm=%h", im), dbg_s2, expv[k]);
                end
                chk("R11 pc after sweep", dbg_pc, 32'd80);
            end
        end

        // memory access and register-zero writes
        clear_rom();
        rom[0] = it_w(6'h09, 0, 16, 16'h0055);
        rom[1] = it_w(6'h09, 0, 29, 16'h2010);
        rom[2] = it_w(6'h2B, 0, 16, 16'h2004);
        rom[3] = it_w(6'h23, 0, 17, 16'h2004);
        rom[4] = it_w(6'h09, 0, 16, 16'hFFFE);
        rom[5] = it_w(6'h2B, 29, 16, 16'hFFFC);
        rom[6] = it_w(6'h23, 29, 18, 16'hFFFC);
        rom[7] = it_w(6'h09, 0, 0, 16'h0005);
        rom[8] = rt_w(6'h21, 0, 0, 16, 0);
        restart();
        chk("R7 no store strobe on addiu", {31'h0, dmem_we}, 32'h0);
        step(2);
        chk("R7 store strobe", {31'h0, dmem_we}, 32'h1);
        chk("R7 store address", dmem_addr, 32'h0000_2004);
        chk("R7 store data", dmem_wdata, 32'h55);
        step(2);
        chk("R7 load result", dbg_s1, 32'h55);
        chk("R7 ram word stored", ram[1], 32'h55);
        step(1);
        chk("R7 negative offset address", dmem_addr, 32'h0000_200C);
        step(2);
        chk("R7 negative offset load", dbg_s2, 32'hFFFF_FFFE);
        chk("R7 negative offset ram", ram[3], 32'hFFFF_FFFE);
        step(2);
        chk("R6 register zero reads zero", dbg_s0, 32'h0);

        // branches: backward loop, untaken and taken forward
        clear_rom();
        rom[0] = it_w(6'h09, 0, 16, 16'd3);
        rom[1] = it_w(6'h09, 0, 17, 16'd0);
        rom[2] = it_w(6'h09, 17, 17, 16'd1);
        rom[3] = it_w(6'h09, 16, 16, 16'hFFFF);
        rom[4] = it_w(6'h05, 16, 0, 16'hFFFD);
        rom[5] = it_w(6'h04, 17, 16, 16'd1);
        rom[6] = it_w(6'h04, 16, 0, 16'd1);
        rom[7] = it_w(6'h09, 0, 18, 16'h0077);
        rom[8] = it_w(6'h09, 18, 18, 16'd1);
        restart();
        step(5);
        chk("R8 bne taken backward", dbg_pc, 32'd8);
        step(6);
        chk("R8 bne untaken at loop exit", dbg_pc, 32'd20);
        step(1);
        chk("R8 beq untaken", dbg_pc, 32'd24);
        step(1);
        chk("R8 beq taken forward", dbg_pc, 32'd32);
        step(1);
        chk("R8 loop count", dbg_s1, 32'd3);
        chk("R8 skipped instruction", dbg_s2, 32'd1);
        step(3);
        chk("R11 zero word advances pc", dbg_pc, 32'd48);
        chk("R11 zero word keeps regs", {dbg_s0, dbg_s2} == {32'd0, 32'd1} ? 32'h1 : 32'h0, 32'h1);

        // jal / j / jr
        clear_rom();
        rom[0] = {6'h03, 26'd4};
        rom[1] = it_w(6'h09, 0, 16, 16'd1);
        rom[2] = {6'h02, 26'd6};
        rom[3] = it_w(6'h09, 0, 17, 16'd9);
        rom[4] = it_w(6'h09, 0, 18, 16'd5);
        rom[5] = rt_w(6'h08, 31, 0, 0, 0);
        rom[6] = it_w(6'h09, 0, 29, 16'd7);
        restart();
        step(1);
        chk("R9 jal link pc+4", dbg_ra, 32'd4);
        chk("R9 jal target", dbg_pc, 32'd16);
        step(2);
        chk("R10 jr return", dbg_pc, 32'd4);
        step(2);
        chk("R9 j target", dbg_pc, 32'd24);
        chk("R12 instr at jump target", dbg_instr, rom[6]);
        step(1);
        chk("R12 sp tap", dbg_sp, 32'd7);
        chk("R9 skipped by j", dbg_s1, 32'd0);
        chk("R10 body ran once", dbg_s0 + dbg_s2, 32'd6);

        finish_run();
    end
endmodule